// File: doc/BRIEF.md
# Exposed-Latency Load Execute Pipeline

This block is the execute part of a load unit in a statically scheduled processor. One load may issue per cycle. The cycle in which a load issues is its first execute phase, E1. The load then moves through phases E2 to E5, and its result reaches the destination register at the end of E5. The pipeline has no interlock on the destination. Instructions scheduled in the four cycles after the load read the register's old contents, so the compiler or the assembly writer is responsible for that spacing.

An address post-modification is different: it takes effect at the end of E1, so the very next instruction sees the stepped base. The load itself uses the base value from before the step. The block holds a register file with three write paths: load results, base post-modification, and writes from other units. A read port lets the rest of the datapath, or a bench, observe any register.

Memory is read in E3 through a simple request/ready port. A memory wait freezes every phase of every in-flight load, and so does the external stall input. A slow memory therefore lengthens the schedule by whole hold cycles and never changes the delay-slot count. The pipeline controller resolves three conditions each cycle:

- **RUN**: every phase advances.
- **EXT_HOLD**: the stall input is high.
- **MEM_WAIT**: a load is in E3 and memory is not ready.

The controller moves between these conditions freely, cycle by cycle, from its inputs. RUN→EXT_HOLD is taken on stall. RUN→MEM_WAIT is taken on a missing ready. Either hold returns to RUN when its cause clears, and EXT_HOLD takes priority over MEM_WAIT.

Top module: `ldx_exec_pipe`

## Requirements
- R1: A load issued (`iss_valid_i` high, `hold_o` low) in cycle t with no hold cycles asserts `wb_en_o` with its destination and data during cycle t+4, and the register is updated at the end of that cycle.
- R2: A read of the destination through `peek_addr_i` returns the old value in cycles t to t+4 and the loaded value from t+5 on.
- R3: With `iss_postinc_i` set, the base register becomes base + `iss_step_i` (two's complement) at the end of the issue cycle. The load's memory address is the base value from before the step.
- R4: Loads issued in consecutive cycles write back in consecutive cycles, one register write per cycle, in issue order.
- R5: `hold_o` is high in any cycle where a load sits in E3 (`mem_req_o` high) and `mem_ready_i` is low. Each such cycle delays every later phase by exactly one cycle and changes nothing else.
- R6: While `hold_o` is high, no phase advances. Issue, post-modification and external writes (`alu_we_i`) are ignored, `wb_en_o` stays low, and `mem_addr_o` holds its value. `stall_i` high always forces `hold_o`. When `hold_o` is low, an external write lands at the end of its cycle.
- R7: `iss_size_i` encodes 00 = byte, 01 = halfword, 10 or 11 = word. The byte lane is address bits [1:0] and the halfword is selected by address bit 1, little-endian. A byte or halfword is zero-extended when `iss_unsigned_i` is 1 and sign-extended otherwise. A word load ignores the address's low bits.
- R8: When several writes target one register at the same edge, the load's E5 write wins over the post-modification, and the post-modification wins over an external write.
- R9: After reset, all registers read zero, no load is in flight, and `hold_o`, `wb_en_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Global stall, freezes the unit |
| iss_valid_i | input | 1 | A load issues this cycle (its E1) |
| iss_base_i | input | RAW | Base address register |
| iss_postinc_i | input | 1 | Step the base at end of E1 |
| iss_step_i | input | 32 | Signed post-modification amount |
| iss_dst_i | input | RAW | Destination register |
| iss_size_i | input | 2 | Access size code |
| iss_unsigned_i | input | 1 | Zero-extend instead of sign-extend |
| alu_we_i | input | 1 | External register write enable |
| alu_waddr_i | input | RAW | External write register |
| alu_wdata_i | input | 32 | External write data |
| peek_addr_i | input | RAW | Observation read register |
| peek_data_o | output | 32 | Observation read data |
| mem_req_o | output | 1 | Memory read request (load in E3) |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_ready_i | input | 1 | Memory data valid this cycle |
| mem_rdata_i | input | 32 | Aligned word containing the address |
| wb_en_o | output | 1 | Load result written this cycle |
| wb_addr_o | output | RAW | Written register |
| wb_data_o | output | 32 | Written data |
| hold_o | output | 1 | Execute unit frozen this cycle |

## Verification
The bench checks several corner cases of the delay-slot contract.

- **Destination read in slots one to four.** The bench reads the destination in each of these cycles and expects the old value. A design that forwarded or interlocked would show the new value too early. An off-by-one pipe would show it one cycle early or late.
- **Load right after a post-incrementing load on the same base.** A design that committed the step late would send the unstepped address to memory.
- **Memory waits and external stalls with several loads in flight.** A design that froze only the waiting load would let younger loads collide or write back out of order, and a design that accepted issue or external writes during a hold would corrupt registers.
- **Same-edge collisions.** The bench drives a load result, a base step and an external write into one register at the same edge. A wrong priority leaves the wrong value.
- **Byte and halfword lanes, both signs, both extension modes.** These expose lane or sign errors.

// File: rtl/ldx_pkg.sv
`timescale 1ns/1ps
package ldx_pkg;

    // Data path width; the extension logic assumes a 32-bit word.
    localparam int XLEN = 32;

    // Number of execute phases a load occupies.
    localparam int NPHASE = 5;

    // Access size codes as seen on the issue port.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } ld_size_e;

    // Condition of the execute unit in the current cycle.
    typedef enum logic [1:0] {
        MODE_RUN      = 2'b00,
        MODE_EXT_HOLD = 2'b01,
        MODE_MEM_WAIT = 2'b10
    } pipe_mode_e;

endpackage

// File: rtl/ldx_regfile.sv
`timescale 1ns/1ps
module ldx_regfile #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_we_i,
    input  logic [RAW-1:0]  ld_addr_i,
    input  logic [XLEN-1:0] ld_data_i,
    input  logic            pi_we_i,
    input  logic [RAW-1:0]  pi_addr_i,
    input  logic [XLEN-1:0] pi_data_i,
    input  logic            ex_we_i,
    input  logic [RAW-1:0]  ex_addr_i,
    input  logic [XLEN-1:0] ex_data_i,
    input  logic [RAW-1:0]  rda_addr_i,
    output logic [XLEN-1:0] rda_data_o,
    input  logic [RAW-1:0]  rdb_addr_i,
    output logic [XLEN-1:0] rdb_data_o
);

    logic [XLEN-1:0] regs_w [NREG];

    // One storage cell per register; priority load > post-step > external (R8).
    for (genvar g = 0; g < NREG; g++) begin : g_cell
        logic [XLEN-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (ld_we_i && ld_addr_i == RAW'(g)) begin
                q <= ld_data_i;
            end else if (pi_we_i && pi_addr_i == RAW'(g)) begin
                q <= pi_data_i;
            end else if (ex_we_i && ex_addr_i == RAW'(g)) begin
                q <= ex_data_i;
            end
        end
        assign regs_w[g] = q;
    end

    assign rda_data_o = regs_w[rda_addr_i];
    assign rdb_data_o = regs_w[rdb_addr_i];

endmodule

// File: rtl/ldx_extend.sv
`timescale 1ns/1ps
module ldx_extend
    import ldx_pkg::*;
(
    input  logic [XLEN-1:0] word_i,
    input  logic [1:0]      lane_i,
    input  ld_size_e        size_i,
    input  logic            unsigned_i,
    output logic [XLEN-1:0] word_o
);

    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = word_i[8*lane_i +: 8];
        half_sel = lane_i[1] ? word_i[31:16] : word_i[15:0];
        unique case (size_i)
            SZ_BYTE: word_o = unsigned_i ? {{(XLEN-8){1'b0}}, byte_sel}
                                         : {{(XLEN-8){byte_sel[7]}}, byte_sel};
            SZ_HALF: word_o = unsigned_i ? {{(XLEN-16){1'b0}}, half_sel}
                                         : {{(XLEN-16){half_sel[15]}}, half_sel};
            SZ_WORD: word_o = word_i;
            SZ_WALT: word_o = word_i;
            default: word_o = word_i;
        endcase
    end

endmodule

// File: rtl/ldx_pipe_ctl.sv
`timescale 1ns/1ps
module ldx_pipe_ctl
    import ldx_pkg::*;
(
    input  logic stall_i,
    input  logic e3_busy_i,
    input  logic mem_ready_i,
    output logic freeze_o
);

    pipe_mode_e mode;

    // Condition select: external hold has priority over a memory wait.
    always_comb begin
        if (stall_i) begin
            mode = MODE_EXT_HOLD;
        end else if (e3_busy_i && !mem_ready_i) begin
            mode = MODE_MEM_WAIT;
        end else begin
            mode = MODE_RUN;
        end
    end

    // Outputs per condition.
    always_comb begin
        unique case (mode)
            MODE_RUN:      freeze_o = 1'b0;
            MODE_EXT_HOLD: freeze_o = 1'b1;
            MODE_MEM_WAIT: freeze_o = 1'b1;
            default:       freeze_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/ldx_exec_pipe.sv
`timescale 1ns/1ps
module ldx_exec_pipe
    import ldx_pkg::*;
#(
    parameter int NREG = 16,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic            iss_valid_i,
    input  logic [RAW-1:0]  iss_base_i,
    input  logic            iss_postinc_i,
    input  logic [XLEN-1:0] iss_step_i,
    input  logic [RAW-1:0]  iss_dst_i,
    input  logic [1:0]      iss_size_i,
    input  logic            iss_unsigned_i,
    input  logic            alu_we_i,
    input  logic [RAW-1:0]  alu_waddr_i,
    input  logic [XLEN-1:0] alu_wdata_i,
    input  logic [RAW-1:0]  peek_addr_i,
    output logic [XLEN-1:0] peek_data_o,
    output logic            mem_req_o,
    output logic [XLEN-1:0] mem_addr_o,
    input  logic            mem_ready_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output logic            wb_en_o,
    output logic [RAW-1:0]  wb_addr_o,
    output logic [XLEN-1:0] wb_data_o,
    output logic            hold_o
);

    localparam int FIRST = 2;
    localparam int LAST  = NPHASE;

    // Phase slots E2..E5; E1 is the issue cycle itself.
    logic            sl_v    [FIRST:LAST];
    logic [RAW-1:0]  sl_dst  [FIRST:LAST];
    ld_size_e        sl_sz   [FIRST:LAST];
    logic            sl_uns  [FIRST:LAST];
    logic [1:0]      sl_lane [FIRST:LAST];
    logic [XLEN-1:0] sl_word [FIRST:LAST];

    logic            freeze;
    logic            go;
    logic [XLEN-1:0] base_val;
    logic [XLEN-1:0] ext_word;
    logic            pi_we;
    logic            ex_we;
    logic            ld_we;

    ldx_pipe_ctl u_ctl (
        .stall_i     (stall_i),
        .e3_busy_i   (sl_v[3]),
        .mem_ready_i (mem_ready_i),
        .freeze_o    (freeze)
    );

    assign go    = iss_valid_i && !freeze;
    assign pi_we = go && iss_postinc_i;
    assign ex_we = alu_we_i && !freeze;
    assign ld_we = sl_v[LAST] && !freeze;

    ldx_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we_i    (ld_we),
        .ld_addr_i  (sl_dst[LAST]),
        .ld_data_i  (sl_word[LAST]),
        .pi_we_i    (pi_we),
        .pi_addr_i  (iss_base_i),
        .pi_data_i  (base_val + iss_step_i),
        .ex_we_i    (ex_we),
        .ex_addr_i  (alu_waddr_i),
        .ex_data_i  (alu_wdata_i),
        .rda_addr_i (iss_base_i),
        .rda_data_o (base_val),
        .rdb_addr_i (peek_addr_i),
        .rdb_data_o (peek_data_o)
    );

    ldx_extend u_ext (
        .word_i     (sl_word[4]),
        .lane_i     (sl_lane[4]),
        .size_i     (sl_sz[4]),
        .unsigned_i (sl_uns[4]),
        .word_o     (ext_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = FIRST; k <= LAST; k++) begin
                sl_v[k]    <= 1'b0;
                sl_dst[k]  <= '0;
                sl_sz[k]   <= SZ_WORD;
                sl_uns[k]  <= 1'b0;
                sl_lane[k] <= '0;
                sl_word[k] <= '0;
            end
        end else if (!freeze) begin
            sl_v[FIRST]    <= go;
            sl_dst[FIRST]  <= iss_dst_i;
            sl_sz[FIRST]   <= ld_size_e'(iss_size_i);
            sl_uns[FIRST]  <= iss_unsigned_i;
            sl_lane[FIRST] <= base_val[1:0];
            sl_word[FIRST] <= base_val;
            for (int k = FIRST + 1; k <= LAST; k++) begin
                sl_v[k]    <= sl_v[k-1];
                sl_dst[k]  <= sl_dst[k-1];
                sl_sz[k]   <= sl_sz[k-1];
                sl_uns[k]  <= sl_uns[k-1];
                sl_lane[k] <= sl_lane[k-1];
            end
            sl_word[3]    <= sl_word[2];
            sl_word[4]    <= mem_rdata_i;
            sl_word[LAST] <= ext_word;
        end
    end

    assign mem_req_o  = sl_v[3];
    assign mem_addr_o = sl_word[3];
    assign wb_en_o    = ld_we;
    assign wb_addr_o  = sl_dst[LAST];
    assign wb_data_o  = sl_word[LAST];
    assign hold_o     = freeze;

endmodule

// File: rtl/ldx_exec_pipe_chk.sv
`timescale 1ns/1ps
module ldx_exec_pipe_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall_i,
    input logic            iss_valid_i,
    input logic            hold_o,
    input logic            wb_en_o,
    input logic            mem_req_o,
    input logic [XLEN-1:0] mem_addr_o,
    input logic            mem_ready_i
);

    // Independent occupancy shadow: bit k means an accepted load is in E(k+2).
    logic [3:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (!hold_o) begin
            sh <= {sh[2:0], iss_valid_i};
        end
    end

    a_r1_wb_only_from_e5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> sh[3]);

    a_r1_e5_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (sh[3] && !hold_o) |-> wb_en_o);

    a_r4_req_tracks_e3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o == sh[1]);

    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |-> hold_o);

    a_r6_stall_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> (hold_o && !wb_en_o));

    a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && hold_o) |=> (mem_req_o && $stable(mem_addr_o)));

endmodule

bind ldx_exec_pipe ldx_exec_pipe_chk #(.XLEN(ldx_pkg::XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .iss_valid_i (iss_valid_i),
    .hold_o      (hold_o),
    .wb_en_o     (wb_en_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i)
);

// File: tb/tb_ldx_exec_pipe.sv
`timescale 1ns/1ps
module tb_ldx_exec_pipe;

    localparam int PERIOD = 20;
    localparam int NREG   = 16;
    localparam int RAW    = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            stall_i;
    logic            iss_valid_i;
    logic [RAW-1:0]  iss_base_i;
    logic            iss_postinc_i;
    logic [31:0]     iss_step_i;
    logic [RAW-1:0]  iss_dst_i;
    logic [1:0]      iss_size_i;
    logic            iss_unsigned_i;
    logic            alu_we_i;
    logic [RAW-1:0]  alu_waddr_i;
    logic [31:0]     alu_wdata_i;
    logic [RAW-1:0]  peek_addr_i;
    logic [31:0]     peek_data_o;
    logic            mem_req_o;
    logic [31:0]     mem_addr_o;
    logic            mem_ready_i;
    logic [31:0]     mem_rdata_i;
    logic            wb_en_o;
    logic [RAW-1:0]  wb_addr_o;
    logic [31:0]     wb_data_o;
    logic            hold_o;

    always #(PERIOD/2) clk = ~clk;

    ldx_exec_pipe #(.NREG(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .iss_valid_i(iss_valid_i), .iss_base_i(iss_base_i),
        .iss_postinc_i(iss_postinc_i), .iss_step_i(iss_step_i),
        .iss_dst_i(iss_dst_i), .iss_size_i(iss_size_i),
        .iss_unsigned_i(iss_unsigned_i),
        .alu_we_i(alu_we_i), .alu_waddr_i(alu_waddr_i), .alu_wdata_i(alu_wdata_i),
        .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
        .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
        .hold_o(hold_o)
    );

    // Memory contents: a fixed function of the word address.
    function automatic logic [31:0] memfun(logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h80F1_7E8E;
    endfunction

    assign mem_rdata_i = memfun(mem_addr_o);

    // Size/extension rule from the requirements.
    function automatic logic [31:0] mext(logic [31:0] w, logic [1:0] lane,
                                         logic [1:0] sz, bit uns);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'(w >> (8 * lane));
        h = lane[1] ? w[31:16] : w[15:0];
        if (sz == 2'b00) return uns ? {24'b0, b} : {{24{b[7]}}, b};
        if (sz == 2'b01) return uns ? {16'b0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    // Reference model: register array plus in-flight loads tagged by phase.
    typedef struct {
        int          dst;
        logic [31:0] addr;
        logic [1:0]  sz;
        bit          uns;
        int          ph;
    } ent_t;

    logic [31:0] mreg [NREG];
    ent_t        inflight [$];

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R9";
    int    cycles = 0;

    function automatic bit model_frozen();
        bit e3 = 0;
        foreach (inflight[i]) if (inflight[i].ph == 3) e3 = 1;
        return stall_i || (e3 && !mem_ready_i);
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_now();
        bit fz, req, wb;
        logic [31:0] raddr, wdat;
        int wdst;
        fz = model_frozen();
        req = 0; wb = 0; raddr = '0; wdat = '0; wdst = 0;
        foreach (inflight[i]) begin
            if (inflight[i].ph == 3) begin req = 1; raddr = inflight[i].addr; end
            if (inflight[i].ph == 5) begin
                wb = !fz;
                wdst = inflight[i].dst;
                wdat = mext(memfun(inflight[i].addr), inflight[i].addr[1:0],
                            inflight[i].sz, inflight[i].uns);
            end
        end
        chk("hold_o", 32'(hold_o), 32'(fz));
        chk("mem_req_o", 32'(mem_req_o), 32'(req));
        if (req) chk("mem_addr_o", mem_addr_o, raddr);
        chk("wb_en_o", 32'(wb_en_o), 32'(wb));
        if (wb) begin
            chk("wb_addr_o", 32'(wb_addr_o), 32'(wdst));
            chk("wb_data_o", wb_data_o, wdat);
        end
        for (int r = 0; r < NREG; r++) begin
            peek_addr_i = RAW'(r);
            #0.25;
            chk($sformatf("reg%0d", r), peek_data_o, mreg[r]);
        end
    endtask

    task automatic model_edge();
        logic [31:0] oldr [NREG];
        ent_t nq [$];
        ent_t e;
        if (model_frozen()) return;
        oldr = mreg;
        if (alu_we_i) mreg[alu_waddr_i] = alu_wdata_i;
        if (iss_valid_i && iss_postinc_i) mreg[iss_base_i] = oldr[iss_base_i] + iss_step_i;
        foreach (inflight[i]) begin
            if (inflight[i].ph == 5) begin
                mreg[inflight[i].dst] = mext(memfun(inflight[i].addr), inflight[i].addr[1:0],
                                             inflight[i].sz, inflight[i].uns);
            end else begin
                e = inflight[i];
                e.ph = e.ph + 1;
                nq.push_back(e);
            end
        end
        if (iss_valid_i) begin
            e.dst = int'(iss_dst_i);
            e.addr = oldr[iss_base_i];
            e.sz = iss_size_i;
            e.uns = iss_unsigned_i;
            e.ph = 2;
            nq.push_back(e);
        end
        inflight = nq;
    endtask

    task automatic idle_inputs();
        iss_valid_i = 0; iss_base_i = '0; iss_postinc_i = 0; iss_step_i = '0;
        iss_dst_i = '0; iss_size_i = 2'b10; iss_unsigned_i = 0;
        alu_we_i = 0; alu_waddr_i = '0; alu_wdata_i = '0;
    endtask

    // Inputs are set just after a falling edge; this compares, crosses the edge, updates.
    task automatic tick();
        #1;
        compare_now();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic iss(int base, int dst, logic [1:0] sz, bit uns, bit pi, logic [31:0] step);
        iss_valid_i = 1; iss_base_i = RAW'(base); iss_dst_i = RAW'(dst);
        iss_size_i = sz; iss_unsigned_i = uns; iss_postinc_i = pi; iss_step_i = step;
    endtask

    task automatic wr(int a, logic [31:0] d);
        alu_we_i = 1; alu_waddr_i = RAW'(a); alu_wdata_i = d;
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_up();
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) mreg[r] = '0;
        rst_n = 0; stall_i = 0; mem_ready_i = 1; peek_addr_i = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9: reset state
        cur_req = "R9";
        tick();

        // R6: external writes land when not held (preload)
        cur_req = "R6";
        wr(1, 32'h0000_0100); tick();
        wr(2, 32'h0000_0200); tick();
        wr(4, 32'h1111_1111); tick();
        wr(7, 32'h0000_0300); tick();
        wr(8, 32'h2222_2222); tick();

        // R1/R2: single word load, destination old in slots, new after
        cur_req = "R1";
        iss(1, 4, 2'b10, 0, 0, 0); tick();
        cur_req = "R2";
        repeat (6) tick();

        // R3: post-increment seen by the very next load
        cur_req = "R3";
        iss(2, 5, 2'b10, 0, 1, 32'd4); tick();
        iss(2, 6, 2'b10, 0, 1, 32'hFFFF_FFF8); tick();
        repeat (6) tick();

        // R4: back-to-back loads retire on consecutive cycles
        cur_req = "R4";
        iss(1, 9, 2'b10, 0, 1, 32'd4); tick();
        iss(1, 10, 2'b10, 0, 1, 32'd4); tick();
        iss(1, 11, 2'b10, 0, 1, 32'd4); tick();
        iss(1, 12, 2'b10, 0, 1, 32'd4); tick();
        repeat (6) tick();

        // R5: memory wait adds hold cycles only
        cur_req = "R5";
        iss(2, 13, 2'b10, 0, 0, 0); tick();
        iss(1, 14, 2'b10, 0, 0, 0); tick();
        mem_ready_i = 0;
        iss(2, 15, 2'b10, 0, 1, 32'd8); tick();
        iss(2, 15, 2'b10, 0, 1, 32'd8); tick();
        tick();
        mem_ready_i = 1;
        tick();
        repeat (6) tick();

        // R6: external stall freezes everything, ignores issue and writes
        cur_req = "R6";
        iss(1, 3, 2'b10, 0, 0, 0); tick();
        iss(2, 0, 2'b10, 0, 0, 0); tick();
        iss(1, 5, 2'b10, 0, 0, 0); tick();
        stall_i = 1;
        iss(7, 6, 2'b10, 0, 1, 32'd16); wr(10, 32'hBAD0_BAD0); tick();
        wr(3, 32'hBAD1_BAD1); tick();
        tick();
        stall_i = 0;
        repeat (7) tick();

        // R7: byte and halfword lanes, signed and unsigned
        cur_req = "R7";
        wr(7, 32'h0000_0100); tick();
        iss(7, 9, 2'b00, 0, 1, 32'd1); tick();
        iss(7, 10, 2'b00, 0, 1, 32'd1); tick();
        iss(7, 11, 2'b00, 0, 1, 32'd1); tick();
        iss(7, 12, 2'b00, 0, 1, 32'hFFFF_FFFD); tick();
        iss(7, 13, 2'b00, 1, 1, 32'd3); tick();
        iss(7, 14, 2'b00, 1, 1, 32'hFFFF_FFFF); tick();
        iss(7, 15, 2'b01, 0, 1, 32'hFFFF_FFFE); tick();
        iss(7, 9, 2'b01, 0, 1, 32'd0); tick();
        iss(7, 10, 2'b01, 1, 1, 32'd1); tick();
        iss(7, 11, 2'b11, 0, 0, 32'd0); tick();
        repeat (6) tick();

        // R8: same-edge write collisions
        cur_req = "R8";
        iss(1, 8, 2'b10, 0, 0, 0); tick();
        repeat (3) tick();
        wr(8, 32'hDEAD_BEEF); tick();
        tick();
        iss(2, 0, 2'b10, 0, 1, 32'd4); wr(2, 32'h5555_5555); tick();
        iss(1, 2, 2'b10, 0, 0, 0); tick();
        repeat (3) tick();
        iss(2, 12, 2'b10, 0, 1, 32'd64); wr(2, 32'h7777_7777); tick();
        repeat (6) tick();

        finish_up();
    end

endmodule